// File: doc/BRIEF.md
# Third-Order Fractional Sigma-Delta Interpolator

This block produces the small signed divide offset that a fractional-N feedback divider adds to its integer ratio on every phase-detector reference cycle. It takes a fractional word and an arbitrary integer modulus, both 12 bits wide. Over time the offsets average to FRAC/MOD, so the mean division ratio becomes N + FRAC/MOD. The channel step is therefore one MOD-th of the reference rate.

The core is three cascaded modulo-MOD accumulators. Their carries are merged through a third-order noise-cancelling network, which pushes the quantisation error to high offset frequencies.

An optional dither mode adds the low bit of a 21-bit maximal-length shift register to the first accumulator input. This breaks the short periodic code patterns. A load pulse (or reset) restarts the accumulators, the carry history and the dither register from a fixed state, so one FRAC/MOD pair always gives the same offset sequence. After changing FRAC or MOD, software must issue a load.

Top module: `sdm3_frac_interp`

## Requirements
- R1: `offset_o` is a 4-bit two's complement value and always lies between -3 and +4.
- R2: With dither off, the offsets summed over K steps after a load satisfy |sum*MOD - K*FRAC| <= 3*MOD. This is the frequency-resolution property.
- R3: With dither off, and starting from a load, the sequence repeats with one of the following periods:
  - 2*MOD steps when MOD is even but not a multiple of 3;
  - 3*MOD steps when MOD is a multiple of 3 but is odd;
  - 6*MOD steps when MOD is a multiple of 6;
  - MOD steps otherwise.
- R4: A FRAC input of MOD or more acts as MOD-1. A MOD input below 2 acts as 2.
- R5: With dither requested and MOD >= 50, the sequence differs from the undithered one. Over K steps it still satisfies |sum*MOD - K*FRAC| <= 3*MOD + K. The dither register never reaches the all-zero state, so its period is 2^21-1 steps.
- R6: A dither request has no effect while MOD < 50. The offsets are then identical to those with dither off.
- R7: A load clears the whole state. The offset reads 0 in the cycle after the load. The sequence that follows, dithered or not, is identical to the one after reset. A load wins over a coincident step enable.
- R8: While `en` is low and no load is applied, the offset and all state hold. Resuming continues the sequence as if there had been no pause.
- R9: During and after reset, before any step, the offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Step enable, one pulse per reference cycle |
| load | input | 1 | New-frequency load, clears all state |
| frac_i | input | 12 | Fractional word |
| mod_i | input | 12 | Modulus |
| dither_i | input | 1 | Dither request |
| offset_o | output | 4 | Signed divide offset, -3 to +4 |

## Verification
A step enable and a new-frequency load can fall in the same cycle. In that case the load must win, and no accumulator may advance on the stale values. The bench runs part of a sequence and then raises `load` and `en` together for one cycle. It expects the offset to read 0 in the next cycle. It then expects the following steps to reproduce, value for value, the sequence captured after a clean load. A pause of the step enable is judged the same way, by comparing against an uninterrupted reference run.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;
  localparam int unsigned SDM_WORD_W   = 12;
  localparam int unsigned SDM_OUT_W    = 4;
  localparam int unsigned SDM_STAGES   = 3;
  localparam int unsigned SDM_LFSR_W   = 21;
  localparam int unsigned SDM_LFSR_TAP = 19;
  localparam int unsigned SDM_DITH_MIN = 50;
endpackage

// File: rtl/sdm3_mod_acc.sv
module sdm3_mod_acc #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] modv,
  input  logic [W:0]   addend,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_d,
  output logic         carry_d
);
  localparam int unsigned SW = W + 2;

  logic [SW-1:0] sum_w;
  logic [SW-1:0] diff_w;
  logic [W-1:0]  acc_nxt;

  always_comb begin
    sum_w   = {2'b00, acc_q} + {1'b0, addend};
    diff_w  = sum_w - {2'b00, modv};
    carry_d = (sum_w >= {2'b00, modv});
    acc_d   = carry_d ? diff_w[W-1:0] : sum_w[W-1:0];
  end

  always_comb begin
    if (clr)       acc_nxt = '0;
    else if (step) acc_nxt = acc_d;
    else           acc_nxt = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end
endmodule

// File: rtl/sdm3_dither_lfsr.sv
module sdm3_dither_lfsr #(
  parameter int unsigned LW  = 21,
  parameter int unsigned TAP = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clr,
  output logic [LW-1:0] state_q,
  output logic          dbit
);
  localparam logic [LW-1:0] SEED = {{(LW-1){1'b0}}, 1'b1};

  logic          fb;
  logic [LW-1:0] state_nxt;

  always_comb begin
    fb = state_q[LW-1] ^ state_q[TAP-1];
    if (clr)       state_nxt = SEED;
    else if (step) state_nxt = {state_q[LW-2:0], fb};
    else           state_nxt = state_q;
  end

  assign dbit = state_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_nxt;
  end
endmodule

// File: rtl/sdm3_noise_cancel.sv
module sdm3_noise_cancel #(
  parameter int unsigned OW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 clr,
  input  logic [2:0]           carry,
  output logic signed [OW-1:0] offset
);
  typedef struct packed {
    logic c1;
    logic c2;
    logic c2d;
    logic c3;
    logic c3d;
    logic c3dd;
  } hist_t;

  hist_t h_q, h_nxt;
  logic signed [OW-1:0] e1, e2, e2d, e3, e3d, e3dd;

  always_comb begin
    if (clr) begin
      h_nxt = '0;
    end else if (step) begin
      h_nxt.c1   = carry[0];
      h_nxt.c2   = carry[1];
      h_nxt.c2d  = h_q.c2;
      h_nxt.c3   = carry[2];
      h_nxt.c3d  = h_q.c3;
      h_nxt.c3dd = h_q.c3d;
    end else begin
      h_nxt = h_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_q <= '0;
    else        h_q <= h_nxt;
  end

  assign e1   = {{(OW-1){1'b0}}, h_q.c1};
  assign e2   = {{(OW-1){1'b0}}, h_q.c2};
  assign e2d  = {{(OW-1){1'b0}}, h_q.c2d};
  assign e3   = {{(OW-1){1'b0}}, h_q.c3};
  assign e3d  = {{(OW-1){1'b0}}, h_q.c3d};
  assign e3dd = {{(OW-1){1'b0}}, h_q.c3dd};

  assign offset = e1 + e2 - e2d + e3 - (e3d <<< 1) + e3dd;
endmodule

// File: rtl/sdm3_frac_interp.sv
module sdm3_frac_interp
  import sdm3_pkg::*;
#(
  parameter int unsigned W        = SDM_WORD_W,
  parameter int unsigned OW       = SDM_OUT_W,
  parameter int unsigned LW       = SDM_LFSR_W,
  parameter int unsigned LTAP     = SDM_LFSR_TAP,
  parameter int unsigned DITH_MIN = SDM_DITH_MIN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 load,
  input  logic [W-1:0]         frac_i,
  input  logic [W-1:0]         mod_i,
  input  logic                 dither_i,
  output logic signed [OW-1:0] offset_o
);
  localparam int unsigned NST = SDM_STAGES;
  localparam logic [W-1:0] MOD_FLOOR = W'(2);
  localparam logic [W-1:0] DMIN      = W'(DITH_MIN);

  logic [W-1:0]   mod_eff;
  logic [W-1:0]   frac_eff;
  logic           dith_act;
  logic           dbit;
  logic [LW-1:0]  lfsr_q;
  logic [W:0]     lead_add;
  logic [NST-1:0] carry;
  logic [W-1:0]   acc_lead_q;

  always_comb begin
    mod_eff  = (mod_i < MOD_FLOOR) ? MOD_FLOOR : mod_i;
    frac_eff = (frac_i >= mod_eff) ? (mod_eff - 1'b1) : frac_i;
    dith_act = dither_i && (mod_eff >= DMIN);
    lead_add = {1'b0, frac_eff} + {{W{1'b0}}, (dith_act & dbit)};
  end

  sdm3_dither_lfsr #(.LW(LW), .TAP(LTAP)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (en),
    .clr     (load),
    .state_q (lfsr_q),
    .dbit    (dbit)
  );

  for (genvar g = 0; g < NST; g++) begin : g_stage
    logic [W:0]   add_w;
    logic [W-1:0] acc_q_w;
    logic [W-1:0] acc_d_w;
    logic         cy_w;

    if (g == 0) begin : g_lead
      assign add_w      = lead_add;
      assign acc_lead_q = acc_q_w;
    end else begin : g_cascade
      assign add_w = {1'b0, g_stage[g-1].acc_d_w};
    end

    sdm3_mod_acc #(.W(W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (en),
      .clr     (load),
      .modv    (mod_eff),
      .addend  (add_w),
      .acc_q   (acc_q_w),
      .acc_d   (acc_d_w),
      .carry_d (cy_w)
    );

    assign carry[g] = cy_w;
  end

  sdm3_noise_cancel #(.OW(OW)) u_nc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (en),
    .clr    (load),
    .carry  (carry),
    .offset (offset_o)
  );
endmodule

// File: rtl/sdm3_frac_interp_chk.sv
module sdm3_frac_interp_chk #(
  parameter int unsigned W  = 12,
  parameter int unsigned OW = 4,
  parameter int unsigned LW = 21
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 load,
  input logic signed [OW-1:0] offset,
  input logic [LW-1:0]        lfsr,
  input logic [W-1:0]         acc_lead,
  input logic [W-1:0]         mod_eff
);
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (offset >= -3) && (offset <= 4)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(offset)); // R8

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (offset == 0)); // R7

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R5

  AST_LOAD_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_lead == '0) && (mod_eff >= 2)); // R7
endmodule

bind sdm3_frac_interp sdm3_frac_interp_chk #(.W(W), .OW(OW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .load     (load),
  .offset   (offset_o),
  .lfsr     (lfsr_q),
  .acc_lead (acc_lead_q),
  .mod_eff  (mod_eff)
);

// File: tb/sdm3_frac_interp_tb.sv
`timescale 1ns/1ps
module sdm3_frac_interp_tb;
  logic              clk;
  logic              rst_n;
  logic              en;
  logic              load;
  logic [11:0]       frac;
  logic [11:0]       modv;
  logic              dith;
  logic signed [3:0] off;

  int nchk;
  int nfail;
  int bufa [512];
  int bufb [512];

  typedef struct packed {
    logic [11:0] m;
    logic [11:0] f;
    logic [15:0] per;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{12'd12, 12'd5, 16'd72},
    '{12'd10, 12'd3, 16'd20},
    '{12'd9,  12'd4, 16'd27},
    '{12'd7,  12'd3, 16'd7},
    '{12'd25, 12'd7, 16'd25},
    '{12'd8,  12'd3, 16'd16},
    '{12'd6,  12'd1, 16'd36}
  };

  sdm3_frac_interp u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (load),
    .frac_i   (frac),
    .mod_i    (modv),
    .dither_i (dith),
    .offset_o (off)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic capture(input int n, input bit to_b, input int start);
    for (int i = 0; i < n; i++) begin
      en = 1'b1;
      @(negedge clk);
      if (to_b) bufb[start+i] = int'(off);
      else      bufa[start+i] = int'(off);
    end
    en = 1'b0;
  endtask

  task automatic do_load();
    en   = 1'b0;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  function automatic int diff_ab(input int n);
    int d = 0;
    for (int i = 0; i < n; i++) if (bufa[i] != bufb[i]) d++;
    return d;
  endfunction

  initial begin
    #(5.0 * 190000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    nchk  = 0;
    nfail = 0;
    rst_n = 1'b0;
    en    = 1'b0;
    load  = 1'b0;
    frac  = 12'd0;
    modv  = 12'd2;
    dith  = 1'b0;
    repeat (3) @(negedge clk);
    chk(off == 0, "R9 in reset", int'(off), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(off == 0, "R9 after reset", int'(off), 0);

    // Vector table: periodicity (R3) and mean (R2)
    for (int v = 0; v < 7; v++) begin
      int per, mism, sum, err;
      per  = int'(VEC[v].per);
      modv = VEC[v].m;
      frac = VEC[v].f;
      dith = 1'b0;
      do_load();
      chk(off == 0, "R7 load zero", int'(off), 0);
      capture(2 * per, 1'b0, 0);
      mism = 0;
      sum  = 0;
      for (int i = 0; i < per; i++) begin
        if (bufa[i] != bufa[i+per]) mism++;
        sum += bufa[i];
        if (bufa[i] < -3 || bufa[i] > 4) mism++;
      end
      chk(mism == 0, $sformatf("R3 R1 period mod=%0d", VEC[v].m), mism, 0);
      err = sum * int'(VEC[v].m) - per * int'(VEC[v].f);
      if (err < 0) err = -err;
      chk(err <= 3 * int'(VEC[v].m), $sformatf("R2 mean mod=%0d", VEC[v].m),
          sum, per * int'(VEC[v].f) / int'(VEC[v].m));
    end

    // R4: FRAC clamp
    modv = 12'd10; dith = 1'b0;
    frac = 12'd9;  do_load(); capture(40, 1'b0, 0);
    frac = 12'd15; do_load(); capture(40, 1'b1, 0);
    chk(diff_ab(40) == 0, "R4 frac clamp", diff_ab(40), 0);
    // R4: MOD floor
    frac = 12'd1;
    modv = 12'd2; do_load(); capture(20, 1'b0, 0);
    modv = 12'd0; do_load(); capture(20, 1'b1, 0);
    chk(diff_ab(20) == 0, "R4 mod floor", diff_ab(20), 0);

    // R6: dither ignored below the minimum modulus
    modv = 12'd40; frac = 12'd7;
    dith = 1'b0; do_load(); capture(200, 1'b0, 0);
    dith = 1'b1; do_load(); capture(200, 1'b1, 0);
    chk(diff_ab(200) == 0, "R6 dither ignored", diff_ab(200), 0);

    // R5: dither active
    modv = 12'd100; frac = 12'd37;
    dith = 1'b0; do_load(); capture(400, 1'b0, 0);
    dith = 1'b1; do_load(); capture(400, 1'b1, 0);
    chk(diff_ab(400) != 0, "R5 dither changes sequence", diff_ab(400), 1);
    begin
      int s, e;
      s = 0;
      for (int i = 0; i < 400; i++) s += bufb[i];
      e = s * 100 - 400 * 37;
      if (e < 0) e = -e;
      chk(e <= 300 + 400, "R5 dithered mean", s, 148);
    end
    // R7: dithered sequence reproducible after load
    for (int i = 0; i < 400; i++) bufa[i] = bufb[i];
    do_load(); capture(400, 1'b1, 0);
    chk(diff_ab(400) == 0, "R7 dither repeat after load", diff_ab(400), 0);
    // R7: same after reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    capture(400, 1'b1, 0);
    chk(diff_ab(400) == 0, "R7 dither repeat after reset", diff_ab(400), 0);

    // R8: pause of the step enable
    modv = 12'd9; frac = 12'd4; dith = 1'b0;
    do_load(); capture(30, 1'b0, 0);
    do_load(); capture(10, 1'b1, 0);
    begin
      int held;
      held = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (int'(off) != bufb[9]) held++;
      end
      chk(held == 0, "R8 hold while idle", held, 0);
    end
    capture(20, 1'b1, 10);
    chk(diff_ab(30) == 0, "R8 resume continues", diff_ab(30), 0);

    // R7: load coinciding with a step enable
    modv = 12'd12; frac = 12'd5;
    do_load(); capture(50, 1'b0, 0);
    do_load(); capture(13, 1'b1, 0);
    en   = 1'b1;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    en   = 1'b0;
    chk(off == 0, "R7 load wins over enable", int'(off), 0);
    capture(50, 1'b1, 0);
    chk(diff_ab(50) == 0, "R7 restart after load with enable", diff_ab(50), 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule